// File: doc/BRIEF.md
# Exception Entry Sequencer

The block takes exception requests from fourteen sources, picks one by fixed priority, and carries the processor through exception entry. It keeps the status word and program counter that were live when the exception was accepted. It stores them in one of two shadow pairs. It forms a vector number and the address of the handler's entry in the vector table, and fetches that word through a one-cycle read port. It then presents the new program counter and status word together with a one-cycle pipeline flush.

Fast interrupts save into their own shadow pair. Every other exception uses the exception pair. A fast interrupt taken inside an ordinary handler therefore leaves the state that handler saved intact. A return-from-exception path outside this block restores from the four shadow outputs.

Entry is a four-state sequence: idle, save, vector read, load. A reset request skips the save state. New requests are not looked at until the sequence is back in idle.

Top module: `exc_entry_seq`

## Requirements
- R1: When several eligible request bits of `req_i` are high in the same idle cycle, the one with the lowest bit index is taken.
- R2: `req_i[13]` (normal interrupt) is eligible only while `psr_i[6]` is 1. `req_i[12]` (fast interrupt) is eligible only while `psr_i[4]` is 1. An ineligible request starts no entry.
- R3: The vector number is the source index for indices 0 to 7. For the trap source (index 8) it is 8 plus `trap_op_i`. For indices 9 to 13 it is the index plus 3.
- R4: `vec_rd_o` is high for exactly one cycle, with `vec_addr_o` = `vbr_i` + 4 × vector number. For a non-reset source this is the second cycle after the accepting edge; for a reset request it is the first.
- R5: In the cycle after the read, `flush_o` is high for one cycle and `new_pc_o` equals the word returned on `vec_rdata_i`.
- R6: For a non-reset source, `new_psr_o` is the status word captured at acceptance with bit 31 set and bit 6 cleared. Bit 4 is also cleared when the source is the fast interrupt (index 12).
- R7: A fast interrupt writes the captured PC and status word to `fpc_o`/`fpsr_o` and leaves `epc_o`/`epsr_o` unchanged.
- R8: Any other non-reset source writes the captured PC and status word to `epc_o`/`epsr_o` and leaves `fpc_o`/`fpsr_o` unchanged. The captured values are those of `pc_i`/`psr_i` at the accepting edge.
- R9: A reset request (index 0) changes no shadow register, reads vector 0, and loads `new_psr_o` = 32'h8000_0000.
- R10: Requests and changes to `pc_i` that occur while an entry is in progress have no effect on that entry. They start nothing once the sequence is idle again, provided they are gone by then.
- R11: After `rst_ni` is released, all shadow outputs are 0 and `flush_o` and `vec_rd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 14 | Request lines, index = source and priority |
| trap_op_i | input | 2 | Trap operand selecting one of four trap vectors |
| pc_i | input | 32 | Current program counter |
| psr_i | input | 32 | Current status word |
| vbr_i | input | 32 | Vector table base address |
| vec_rd_o | output | 1 | Vector table read strobe |
| vec_addr_o | output | 32 | Vector table read address |
| vec_rdata_i | input | 32 | Read data, valid the cycle after the strobe |
| flush_o | output | 1 | One-cycle flush with redirect |
| new_pc_o | output | 32 | Handler address, valid with flush |
| new_psr_o | output | 32 | Handler status word, valid with flush |
| epc_o | output | 32 | Exception shadow PC |
| epsr_o | output | 32 | Exception shadow status word |
| fpc_o | output | 32 | Fast-interrupt shadow PC |
| fpsr_o | output | 32 | Fast-interrupt shadow status word |

## Verification
The hardest situation to reach from the ports is a fast interrupt arriving while the exception pair already holds live state. The check must show that only the fast pair moves. The bench runs every source back to back and keeps a model of both pairs, so each fast-interrupt entry follows entries that filled the exception pair. Both pairs are compared after every entry. A second hard case is a higher-priority request, together with a changed PC, raised in the middle of an entry. A dedicated pass holds such a request from the save state through the load state, then confirms the entry is unaltered and that nothing starts afterwards.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int NUM_SRC    = 14;
  localparam int SRC_W      = $clog2(NUM_SRC);
  localparam int VEC_W      = 8;
  localparam int TRAP_SLOTS = 4;
  localparam int TRAP_OP_W  = $clog2(TRAP_SLOTS);

  // source index doubles as priority rank (0 highest)
  localparam int SRC_RESET = 0;
  localparam int SRC_TRAP  = 8;
  localparam int SRC_FIRQ  = 12;
  localparam int SRC_IRQ   = 13;

  localparam int PSR_SUP = 31;
  localparam int PSR_IE  = 6;
  localparam int PSR_FE  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SAVE, ST_VREAD, ST_LOAD} entry_state_e;

  localparam int PAIR_EXC  = 0;
  localparam int PAIR_FAST = 1;

  function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] src,
                                              input logic [TRAP_OP_W-1:0] op);
    if (int'(src) < SRC_TRAP)       return VEC_W'(src);
    else if (int'(src) == SRC_TRAP) return VEC_W'(SRC_TRAP) + VEC_W'(op);
    else                            return VEC_W'(src) + VEC_W'(TRAP_SLOTS - 1);
  endfunction
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_entry_pkg::*;
#(
  parameter int N     = NUM_SRC,
  parameter int IDX_W = SRC_W
) (
  input  logic [N-1:0]     req_i,
  input  logic             irq_en_i,
  input  logic             firq_en_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] src_o
);
  logic [N-1:0] eligible;

  always_comb begin
    eligible           = req_i;
    eligible[SRC_IRQ]  = req_i[SRC_IRQ] & irq_en_i;
    eligible[SRC_FIRQ] = req_i[SRC_FIRQ] & firq_en_i;
    hit_o = |eligible;
    src_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eligible[i]) src_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/exc_shadow_bank.sv
module exc_shadow_bank #(
  parameter int XLEN      = 32,
  parameter int NUM_PAIRS = 2,
  parameter int SEL_W     = $clog2(NUM_PAIRS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [SEL_W-1:0]               wr_sel_i,
  input  logic [XLEN-1:0]                pc_i,
  input  logic [XLEN-1:0]                psr_i,
  output logic [NUM_PAIRS-1:0][XLEN-1:0] pc_o,
  output logic [NUM_PAIRS-1:0][XLEN-1:0] psr_o
);
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pc_o[p]  <= '0;
        psr_o[p] <= '0;
      end else if (wr_en_i && (wr_sel_i == SEL_W'(p))) begin
        pc_o[p]  <= pc_i;
        psr_o[p] <= psr_i;
      end
    end
  end
endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hit_i,
  input  logic [SRC_W-1:0]     src_i,
  input  logic [TRAP_OP_W-1:0] trap_op_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic [XLEN-1:0]      psr_i,
  output entry_state_e         state_o,
  output logic                 is_reset_o,
  output logic                 is_fast_o,
  output logic [VEC_W-1:0]     vec_num_o,
  output logic [XLEN-1:0]      cap_pc_o,
  output logic [XLEN-1:0]      cap_psr_o
);
  entry_state_e state_q, state_d;
  logic         accept;

  assign accept = (state_q == ST_IDLE) && hit_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (hit_i) state_d = (int'(src_i) == SRC_RESET) ? ST_VREAD : ST_SAVE;
      ST_SAVE:  state_d = ST_VREAD;
      ST_VREAD: state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      is_reset_o <= 1'b0;
      is_fast_o  <= 1'b0;
      vec_num_o  <= '0;
      cap_pc_o   <= '0;
      cap_psr_o  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        is_reset_o <= (int'(src_i) == SRC_RESET);
        is_fast_o  <= (int'(src_i) == SRC_FIRQ);
        vec_num_o  <= vec_of(src_i, trap_op_i);
        cap_pc_o   <= pc_i;
        cap_psr_o  <= psr_i;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int               XLEN      = 32,
  parameter logic [XLEN-1:0]  RESET_PSR = 32'h8000_0000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   req_i,
  input  logic [TRAP_OP_W-1:0] trap_op_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic [XLEN-1:0]      psr_i,
  input  logic [XLEN-1:0]      vbr_i,
  output logic                 vec_rd_o,
  output logic [XLEN-1:0]      vec_addr_o,
  input  logic [XLEN-1:0]      vec_rdata_i,
  output logic                 flush_o,
  output logic [XLEN-1:0]      new_pc_o,
  output logic [XLEN-1:0]      new_psr_o,
  output logic [XLEN-1:0]      epc_o,
  output logic [XLEN-1:0]      epsr_o,
  output logic [XLEN-1:0]      fpc_o,
  output logic [XLEN-1:0]      fpsr_o
);
  localparam int NUM_PAIRS = 2;

  logic                          hit;
  logic [SRC_W-1:0]              src;
  entry_state_e                  state;
  logic                          is_reset, is_fast;
  logic [VEC_W-1:0]              vec_num;
  logic [XLEN-1:0]               cap_pc, cap_psr, handler_psr;
  logic [NUM_PAIRS-1:0][XLEN-1:0] bank_pc, bank_psr;

  exc_prio_sel #(.N(NUM_SRC), .IDX_W(SRC_W)) u_prio (
    .req_i     (req_i),
    .irq_en_i  (psr_i[PSR_IE]),
    .firq_en_i (psr_i[PSR_FE]),
    .hit_o     (hit),
    .src_o     (src)
  );

  exc_entry_fsm #(.XLEN(XLEN)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .src_i      (src),
    .trap_op_i  (trap_op_i),
    .pc_i       (pc_i),
    .psr_i      (psr_i),
    .state_o    (state),
    .is_reset_o (is_reset),
    .is_fast_o  (is_fast),
    .vec_num_o  (vec_num),
    .cap_pc_o   (cap_pc),
    .cap_psr_o  (cap_psr)
  );

  exc_shadow_bank #(.XLEN(XLEN), .NUM_PAIRS(NUM_PAIRS)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (state == ST_SAVE),
    .wr_sel_i (is_fast),
    .pc_i     (cap_pc),
    .psr_i    (cap_psr),
    .pc_o     (bank_pc),
    .psr_o    (bank_psr)
  );

  always_comb begin
    handler_psr          = cap_psr;
    handler_psr[PSR_SUP] = 1'b1;
    handler_psr[PSR_IE]  = 1'b0;
    if (is_fast) handler_psr[PSR_FE] = 1'b0;
  end

  assign vec_rd_o   = (state == ST_VREAD);
  assign vec_addr_o = vbr_i + (XLEN'(vec_num) << 2);
  assign flush_o    = (state == ST_LOAD);
  assign new_pc_o   = flush_o ? vec_rdata_i : '0;
  assign new_psr_o  = !flush_o ? '0 : (is_reset ? RESET_PSR : handler_psr);

  assign epc_o  = bank_pc[PAIR_EXC];
  assign epsr_o = bank_psr[PAIR_EXC];
  assign fpc_o  = bank_pc[PAIR_FAST];
  assign fpsr_o = bank_psr[PAIR_FAST];
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            vec_rd_i,
  input logic            flush_i,
  input logic [XLEN-1:0] new_psr_i,
  input logic [XLEN-1:0] epc_i,
  input logic [XLEN-1:0] epsr_i,
  input logic [XLEN-1:0] fpc_i,
  input logic [XLEN-1:0] fpsr_i
);
  AST_READ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd_i |=> !vec_rd_i); // R4
  AST_FLUSH_FOLLOWS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd_i |=> flush_i); // R5
  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !flush_i); // R5
  AST_FLUSH_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> $past(vec_rd_i)); // R5
  AST_SUPERVISOR_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> new_psr_i[31]); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !new_psr_i[6]); // R6
  AST_PAIRS_EXCLUSIVE_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(epc_i) && !$stable(fpc_i))); // R7
  AST_PAIRS_EXCLUSIVE_PSR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(epsr_i) && !$stable(fpsr_i))); // R8
  AST_NO_SAVE_DURING_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ($stable(epc_i) && $stable(fpc_i))); // R10
endmodule

bind exc_entry_seq exc_entry_checker #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .vec_rd_i  (vec_rd_o),
  .flush_i   (flush_o),
  .new_psr_i (new_psr_o),
  .epc_i     (epc_o),
  .epsr_i    (epsr_o),
  .fpc_i     (fpc_o),
  .fpsr_i    (fpsr_o)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] req_i = '0;
  logic [1:0]  trap_op_i = '0;
  logic [31:0] pc_i = '0, psr_i = '0, vbr_i = '0;
  logic        vec_rd_o, flush_o;
  logic [31:0] vec_addr_o, vec_rdata_i, new_pc_o, new_psr_o;
  logic [31:0] epc_o, epsr_o, fpc_o, fpsr_o;
  logic [31:0] mem_q = '0;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_epc = '0, m_epsr = '0, m_fpc = '0, m_fpsr = '0;

  exc_entry_seq u_exc_entry_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .trap_op_i(trap_op_i),
    .pc_i(pc_i), .psr_i(psr_i), .vbr_i(vbr_i),
    .vec_rd_o(vec_rd_o), .vec_addr_o(vec_addr_o), .vec_rdata_i(vec_rdata_i),
    .flush_o(flush_o), .new_pc_o(new_pc_o), .new_psr_o(new_psr_o),
    .epc_o(epc_o), .epsr_o(epsr_o), .fpc_o(fpc_o), .fpsr_o(fpsr_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] table_word(input logic [31:0] a);
    return a * 32'd3 + 32'h0000_0100;
  endfunction

  always_ff @(posedge clk_i) if (vec_rd_o) mem_q <= table_word(vec_addr_o);
  assign vec_rdata_i = mem_q;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic int vec_expect(input int s, input int op);
    if (s < 8) return s;
    if (s == 8) return 8 + op;
    return s + 3;
  endfunction

  function automatic bit eligible(input int s, input logic [31:0] psr);
    if (s == 13) return psr[6];
    if (s == 12) return psr[4];
    return 1'b1;
  endfunction

  task automatic check_shadows(input string tag);
    chk({tag, " epc"}, epc_o, m_epc);
    chk({tag, " epsr"}, epsr_o, m_epsr);
    chk({tag, " fpc"}, fpc_o, m_fpc);
    chk({tag, " fpsr"}, fpsr_o, m_fpsr);
  endtask

  // one entry; sb < 0 means single source; disturb injects a mid-entry request
  task automatic run_entry(input int sa, input int sb, input int op,
                           input logic [31:0] pc, input logic [31:0] psr,
                           input logic [31:0] vbr, input bit disturb);
    int win;
    logic [31:0] addr, npsr;
    win = sa;
    if (sb >= 0 && eligible(sb, psr) && (sb < sa || !eligible(sa, psr))) win = sb;
    @(negedge clk_i);
    req_i = '0;
    req_i[sa] = 1'b1;
    if (sb >= 0) req_i[sb] = 1'b1;
    trap_op_i = 2'(op); pc_i = pc; psr_i = psr; vbr_i = vbr;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = '0;
    if (disturb) begin
      req_i[0] = 1'b1; req_i[5] = 1'b1; pc_i = ~pc; trap_op_i = ~trap_op_i;
    end
    if (win != 0) begin
      chk("R4 no read in save cycle", 32'(vec_rd_o), 0);
      @(posedge clk_i);
      @(negedge clk_i);
      if (win == 12) begin m_fpc = pc; m_fpsr = psr; end
      else           begin m_epc = pc; m_epsr = psr; end
    end
    addr = vbr + 32'(vec_expect(win, op)) * 4;
    chk("R4 read strobe", 32'(vec_rd_o), 1);
    chk($sformatf("R3 R1 vector address src%0d", win), vec_addr_o, addr);
    if (win == 0)       check_shadows("R9 untouched");
    else if (win == 12) check_shadows("R7 fast pair");
    else                check_shadows("R8 exception pair");
    @(posedge clk_i);
    @(negedge clk_i);
    if (disturb) begin req_i = '0; pc_i = pc; end
    chk("R5 flush", 32'(flush_o), 1);
    chk("R5 new pc", new_pc_o, table_word(addr));
    if (win == 0) npsr = 32'h8000_0000;
    else begin
      npsr = psr | 32'h8000_0000;
      npsr[6] = 1'b0;
      if (win == 12) npsr[4] = 1'b0;
    end
    chk(win == 0 ? "R9 reset psr" : "R6 new psr", new_psr_o, npsr);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk(disturb ? "R10 flush after" : "R5 flush drop", 32'(flush_o), 0);
      chk(disturb ? "R10 nothing started" : "R4 single read", 32'(vec_rd_o), 0);
    end
    if (disturb) check_shadows("R10 shadows kept");
  endtask

  task automatic masked(input int s, input logic [31:0] psr);
    @(negedge clk_i);
    req_i = '0; req_i[s] = 1'b1; psr_i = psr;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk($sformatf("R2 masked src%0d read", s), 32'(vec_rd_o), 0);
      chk($sformatf("R2 masked src%0d flush", s), 32'(flush_o), 0);
    end
    req_i = '0;
    check_shadows("R2 shadows kept");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 flush", 32'(flush_o), 0);
    chk("R11 read", 32'(vec_rd_o), 0);
    check_shadows("R11 reset");

    for (int s = 0; s < 14; s++) begin
      for (int op = 0; op < ((s == 8) ? 4 : 1); op++) begin
        run_entry(s, -1, op, 32'h1000_0000 + 32'(s * 16 + op),
                  32'h0000_0050 | 32'(s << 8) | 32'(op << 20),
                  32'h0002_0000 + 32'(s * 256), 1'b0);
      end
    end

    // R7: fast interrupt after an exception filled the E pair
    run_entry(5, -1, 0, 32'h2222_0000, 32'h0000_0051, 32'h0003_0000, 1'b0);
    run_entry(12, -1, 0, 32'h3333_0000, 32'h0000_0052, 32'h0003_0000, 1'b0);

    for (int a = 0; a < 14; a++) begin
      for (int b = a + 1; b < 14; b++) begin
        run_entry(b, a, 1, 32'h4000_0000 + 32'(a * 64 + b),
                  32'h0000_0050, 32'h0001_0000 + 32'(b * 16), 1'b0);
      end
    end

    masked(13, 32'h0000_0010);
    masked(12, 32'h0000_0040);
    run_entry(12, 13, 0, 32'h5000_0000, 32'h0000_0040, 32'h0005_0000, 1'b0); // R2
    run_entry(13, -1, 0, 32'h6000_0000, 32'h0000_0050, 32'h0006_0000, 1'b1); // R10
    run_entry(12, -1, 0, 32'h7000_0000, 32'h0000_0050, 32'h0007_0000, 1'b1); // R10

    summary();
    $finish;
  end
endmodule